// File: doc/BRIEF.md
# Dual-Link Output Fan-Out with Merged Flow Control

This block takes 32-bit words from a front-end stream and copies each accepted word, together with its end-of-fragment flag, to two outbound link framers in the same cycle. One is the primary readout link. The other is a secondary link that feeds a track-trigger processor. Each link returns an XOFF line. The block merges the two lines into one back-pressure signal toward the front end, so both links always see the same word sequence.

The secondary link cannot stall the data path unless software has set a throttle-enable bit. That bit is cleared at reset. It is written by a command strobe with an 8-bit code that arrives from the secondary link's return-line decoder, and its value is shown on a status pin.

The block follows the secondary link's up/down state, but it only changes between fragments. When that link is down, the block runs as a primary-only path on its own, with no setup needed.

Top module: `dual_link_fanout`

## Requirements
- R1: In every cycle with `in_valid` high and `in_ready` high, the word is accepted. In that same cycle `daq_valid` is high, and `daq_data` and `daq_eof` equal `in_data` and `in_eof`. If the secondary link is active (`ftk_active` high), `ftk_valid` is also high and `ftk_data` and `ftk_eof` carry the same word and flag. In any other cycle, both valid outputs are low.
- R2: While `daq_xoff` is high, `in_ready` is low in that same cycle, whatever the other inputs are.
- R3: `ftk_xoff` drives `in_ready` low only when all three hold: `xoff_enable` is 1, `ftk_active` is 1, and `ftk_link_up` is 1.
- R4: While reset is asserted and just after it, `xoff_enable` reads 0 and `ftk_active` reads 0.
- R5: A cycle with `cmd_strobe` high and `cmd_code` = 8'h01 makes `xoff_enable` 1 from the next cycle. Code 8'h00 makes it 0 from the next cycle. Any other code, and any cycle without the strobe, leaves it unchanged.
- R6: While `ftk_active` is 0, `ftk_valid` stays low. While `ftk_link_up` is 0, `ftk_xoff` has no effect on `in_ready`. Neither case changes `xoff_enable`.
- R7: `ftk_active` takes the value of `ftk_link_up` only on a clock edge where no fragment is open and no multi-word fragment starts. A fragment is open from the acceptance of a word with `in_eof` low until the acceptance of a word with `in_eof` high. A change of `ftk_link_up` in the middle of a fragment shows on `ftk_active` one cycle after that fragment's last word, provided the link state has no further change before then.
- R8: There is no timeout. A held XOFF stalls acceptance for any number of cycles, and `in_ready` returns high in the same cycle the XOFF drops.
- R9: While `xoff_enable` is 0, `in_ready` equals the inverse of `daq_xoff`, whatever the secondary link does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Front-end word valid |
| in_data | input | 32 | Front-end word |
| in_eof | input | 1 | Word closes a fragment |
| in_ready | output | 1 | Block can accept a word (low means hold) |
| daq_valid | output | 1 | Word valid toward primary link |
| daq_data | output | 32 | Word toward primary link |
| daq_eof | output | 1 | Fragment end toward primary link |
| daq_xoff | input | 1 | Primary link requests stop |
| ftk_valid | output | 1 | Word valid toward secondary link |
| ftk_data | output | 32 | Word toward secondary link |
| ftk_eof | output | 1 | Fragment end toward secondary link |
| ftk_xoff | input | 1 | Secondary link requests stop |
| ftk_link_up | input | 1 | Secondary link is synchronized |
| cmd_strobe | input | 1 | Return-line command present |
| cmd_code | input | 8 | Return-line command code |
| xoff_enable | output | 1 | Secondary throttle-enable bit |
| ftk_active | output | 1 | Secondary link currently carries data |

## Verification
The checker assumes that the front end keeps `in_data` and `in_eof` stable while `in_valid` waits, and that a fragment always ends with a word that has `in_eof` set. It also assumes that the link-state and command inputs change only at clock-edge boundaries. The bench drives every input shortly after the falling edge and closes every fragment it opens. Link-state changes are made both in idle gaps and in the middle of a fragment, so the boundary rule is tested against stimulus that stays within these assumptions.

// File: rtl/fanout_pkg.sv
package fanout_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned CMD_W  = 8;
  localparam logic [CMD_W-1:0] CMD_THROTTLE_ON  = 8'h01;
  localparam logic [CMD_W-1:0] CMD_THROTTLE_OFF = 8'h00;

  typedef struct packed {
    logic [WORD_W-1:0] data;
    logic              eof;
  } beat_t;
endpackage

// File: rtl/fanout_cmd_reg.sv
module fanout_cmd_reg
  import fanout_pkg::*;
#(
  parameter int unsigned CODE_W = CMD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic [CODE_W-1:0] code,
  output logic              enable
);
  localparam logic [CODE_W-1:0] SET_CODE = CODE_W'(CMD_THROTTLE_ON);
  localparam logic [CODE_W-1:0] CLR_CODE = CODE_W'(CMD_THROTTLE_OFF);

  logic en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else if (strobe) begin
      if (code == SET_CODE)      en_q <= 1'b1;
      else if (code == CLR_CODE) en_q <= 1'b0;
    end
  end

  assign enable = en_q;
endmodule

// File: rtl/fanout_link_track.sv
module fanout_link_track (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic eof,
  input  logic link_up,
  output logic active
);
  logic open_q;
  logic active_q;
  logic starts_multi;

  assign starts_multi = accept & ~eof;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
    end else if (accept) begin
      open_q <= ~eof;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
    end else if (!open_q && !starts_multi) begin
      active_q <= link_up;
    end
  end

  assign active = active_q;
endmodule

// File: rtl/fanout_hold_merge.sv
module fanout_hold_merge #(
  parameter int unsigned N_SEC = 1
) (
  input  logic             pri_xoff,
  input  logic [N_SEC-1:0] sec_xoff,
  input  logic [N_SEC-1:0] sec_enable,
  input  logic [N_SEC-1:0] sec_active,
  input  logic [N_SEC-1:0] sec_up,
  output logic             hold
);
  logic [N_SEC-1:0] gated;

  for (genvar g = 0; g < N_SEC; g++) begin : g_gate
    assign gated[g] = sec_xoff[g] & sec_enable[g] & sec_active[g] & sec_up[g];
  end

  assign hold = pri_xoff | (|gated);
endmodule

// File: rtl/dual_link_fanout.sv
module dual_link_fanout
  import fanout_pkg::*;
#(
  parameter int unsigned DATA_W = WORD_W,
  parameter int unsigned CODE_W = CMD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_eof,
  output logic              in_ready,
  output logic              daq_valid,
  output logic [DATA_W-1:0] daq_data,
  output logic              daq_eof,
  input  logic              daq_xoff,
  output logic              ftk_valid,
  output logic [DATA_W-1:0] ftk_data,
  output logic              ftk_eof,
  input  logic              ftk_xoff,
  input  logic              ftk_link_up,
  input  logic              cmd_strobe,
  input  logic [CODE_W-1:0] cmd_code,
  output logic              xoff_enable,
  output logic              ftk_active
);
  logic hold;
  logic accept;
  logic en;
  logic act;

  fanout_cmd_reg #(.CODE_W(CODE_W)) u_cmd (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (cmd_strobe),
    .code   (cmd_code),
    .enable (en)
  );

  fanout_link_track u_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (accept),
    .eof     (in_eof),
    .link_up (ftk_link_up),
    .active  (act)
  );

  fanout_hold_merge #(.N_SEC(1)) u_merge (
    .pri_xoff   (daq_xoff),
    .sec_xoff   (ftk_xoff),
    .sec_enable (en),
    .sec_active (act),
    .sec_up     (ftk_link_up),
    .hold       (hold)
  );

  assign in_ready    = ~hold;
  assign accept      = in_valid & ~hold;

  assign daq_valid   = accept;
  assign daq_data    = in_data;
  assign daq_eof     = in_eof;

  assign ftk_valid   = accept & act;
  assign ftk_data    = in_data;
  assign ftk_eof     = in_eof;

  assign xoff_enable = en;
  assign ftk_active  = act;
endmodule

// File: rtl/dual_link_fanout_chk.sv
module dual_link_fanout_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CODE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [DATA_W-1:0] in_data,
  input logic              in_eof,
  input logic              in_ready,
  input logic              daq_valid,
  input logic [DATA_W-1:0] daq_data,
  input logic              daq_eof,
  input logic              daq_xoff,
  input logic              ftk_valid,
  input logic [DATA_W-1:0] ftk_data,
  input logic              ftk_eof,
  input logic              ftk_xoff,
  input logic              ftk_link_up,
  input logic              cmd_strobe,
  input logic [CODE_W-1:0] cmd_code,
  input logic              xoff_enable,
  input logic              ftk_active
);
  logic frag_open;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         frag_open <= 1'b0;
    else if (daq_valid) frag_open <= ~daq_eof;
  end

  assert_fanout_both_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ftk_valid |-> (daq_valid && ftk_data == daq_data && ftk_eof == daq_eof && daq_data == in_data));

  assert_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    daq_valid |-> (in_valid && in_ready));

  assert_daq_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    daq_xoff |-> (!in_ready && !daq_valid));

  assert_passive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!xoff_enable && !daq_xoff) |-> in_ready);

  assert_down_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ftk_link_up && !daq_xoff) |-> in_ready);

  assert_inactive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ftk_active |-> !ftk_valid);

  assert_cmd_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_strobe && cmd_code == 8'h01) |=> xoff_enable);

  assert_cmd_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_strobe && cmd_code == 8'h00) |=> !xoff_enable);

  assert_cmd_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_strobe || (cmd_code != 8'h00 && cmd_code != 8'h01)) |=> $stable(xoff_enable));

  assert_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (frag_open || (daq_valid && !daq_eof)) |=> $stable(ftk_active));
endmodule

bind dual_link_fanout dual_link_fanout_chk #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_chk (.*);

// File: tb/tb_dual_link_fanout.sv
module tb_dual_link_fanout;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_eof = 1'b0;
  logic        in_ready;
  logic        daq_valid;
  logic [31:0] daq_data;
  logic        daq_eof;
  logic        daq_xoff = 1'b0;
  logic        ftk_valid;
  logic [31:0] ftk_data;
  logic        ftk_eof;
  logic        ftk_xoff = 1'b0;
  logic        ftk_link_up = 1'b0;
  logic        cmd_strobe = 1'b0;
  logic [7:0]  cmd_code = '0;
  logic        xoff_enable;
  logic        ftk_active;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  dual_link_fanout dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic send_cmd(input logic [7:0] c);
    cmd_strobe = 1'b1; cmd_code = c;
    tick();
    cmd_strobe = 1'b0; cmd_code = 8'hA5;
    #1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) tick();
    #1;
    chk(xoff_enable == 1'b0, "R4 enable in reset", xoff_enable, 0);
    chk(ftk_active == 1'b0, "R4 active in reset", ftk_active, 0);
    rst_n = 1'b1;
    tick(); #1;
    chk(xoff_enable == 1'b0, "R4 enable after reset", xoff_enable, 0);
    chk(ftk_active == 1'b0, "R4 active after reset", ftk_active, 0);
  endtask

  task automatic t_daq_only();
    in_valid = 1'b1; in_data = 32'hCAFE_0001; in_eof = 1'b1; #1;
    chk(daq_valid && daq_data == 32'hCAFE_0001 && daq_eof, "R1 daq copy", daq_data, 32'hCAFE_0001);
    chk(ftk_valid == 1'b0, "R6 ftk quiet when down", ftk_valid, 0);
    ftk_xoff = 1'b1; #1;
    chk(in_ready == 1'b1, "R6 ftk xoff ignored when down", in_ready, 1);
    tick(); in_valid = 1'b0; ftk_xoff = 1'b0; #1;
    chk(daq_valid == 1'b0, "R1 no valid when idle", daq_valid, 0);
  endtask

  task automatic t_daq_xoff();
    in_valid = 1'b1; in_data = 32'h1234_5678; in_eof = 1'b1; daq_xoff = 1'b1; #1;
    chk(in_ready == 1'b0, "R2 daq xoff holds", in_ready, 0);
    chk(daq_valid == 1'b0, "R1 no accept under hold", daq_valid, 0);
    tick(); daq_xoff = 1'b0; #1;
    chk(in_ready && daq_valid, "R2 release", {in_ready, daq_valid}, 2'b11);
    tick(); in_valid = 1'b0;
  endtask

  task automatic t_both_links();
    ftk_link_up = 1'b1;
    tick(); #1;
    chk(ftk_active == 1'b1, "R7 active follows at boundary", ftk_active, 1);
    in_valid = 1'b1; in_data = 32'hBEEF_0002; in_eof = 1'b0; #1;
    chk(ftk_valid && ftk_data == 32'hBEEF_0002 && !ftk_eof, "R1 ftk copy", ftk_data, 32'hBEEF_0002);
    tick(); in_data = 32'hBEEF_0003; in_eof = 1'b1; #1;
    chk(ftk_valid && daq_valid && ftk_eof && daq_eof, "R1 eof on both", {ftk_eof, daq_eof}, 2'b11);
    tick(); in_valid = 1'b0; #1;
  endtask

  task automatic t_gate();
    ftk_xoff = 1'b1; in_valid = 1'b1; in_eof = 1'b1; in_data = 32'h0000_0044; #1;
    chk(in_ready == 1'b1, "R9 enable clear ftk passive", in_ready, 1);
    in_valid = 1'b0;
    send_cmd(8'h01);
    chk(xoff_enable == 1'b1, "R5 set code", xoff_enable, 1);
    chk(in_ready == 1'b0, "R3 ftk xoff holds when enabled", in_ready, 0);
    send_cmd(8'h55);
    chk(xoff_enable == 1'b1, "R5 other code ignored", xoff_enable, 1);
    ftk_link_up = 1'b0; #1;
    chk(in_ready == 1'b1, "R6 link down ignores xoff", in_ready, 1);
    tick(); #1;
    chk(xoff_enable == 1'b1, "R6 enable kept while down", xoff_enable, 1);
    chk(ftk_active == 1'b0, "R7 idle link drop", ftk_active, 0);
    ftk_link_up = 1'b1; tick(); #1;
    send_cmd(8'h00);
    chk(xoff_enable == 1'b0, "R5 clear code", xoff_enable, 0);
    chk(in_ready == 1'b1, "R3 no hold once disabled", in_ready, 1);
    ftk_xoff = 1'b0;
  endtask

  task automatic t_boundary();
    in_valid = 1'b1; in_data = 32'h0000_0100; in_eof = 1'b0;
    tick();
    ftk_link_up = 1'b0; in_data = 32'h0000_0101; #1;
    chk(ftk_active == 1'b1 && ftk_valid, "R7 mid fragment keeps active", ftk_active, 1);
    tick(); in_data = 32'h0000_0102; in_eof = 1'b1; #1;
    chk(ftk_valid == 1'b1, "R7 last word still to ftk", ftk_valid, 1);
    tick(); in_valid = 1'b0; in_eof = 1'b0; #1;
    chk(ftk_active == 1'b1, "R7 not yet switched", ftk_active, 1);
    tick(); #1;
    chk(ftk_active == 1'b0, "R7 switched after fragment", ftk_active, 0);
  endtask

  task automatic t_long_hold();
    in_valid = 1'b1; in_data = 32'hFACE_0007; in_eof = 1'b1; daq_xoff = 1'b1;
    repeat (2000) tick();
    #1;
    chk(in_ready == 1'b0 && daq_valid == 1'b0, "R8 long hold no timeout", in_ready, 0);
    daq_xoff = 1'b0; #1;
    chk(in_ready && daq_valid && daq_data == 32'hFACE_0007, "R8 resume same cycle", daq_data, 32'hFACE_0007);
    tick(); in_valid = 1'b0;
  endtask

  initial begin
    t_reset();
    t_daq_only();
    t_daq_xoff();
    t_both_links();
    t_gate();
    t_boundary();
    t_long_hold();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule